// File: doc/BRIEF.md
# I2C Bus Watcher with Arbitration-Loss Detection

This block runs beside an I2C master engine and watches the two open-drain bus lines. It samples SCL and SDA through a short synchroniser. From those samples it finds START and STOP conditions and keeps two status bits from which software can tell whether the bus is free. It also decides whether a new START request from the engine may go ahead.

While the engine has a condition or a transmit byte in progress, it reports the SDA level it means to drive. The watcher compares that level with the line while SCL is high. If the engine has released SDA and the line is sampled low, another master has won the bus. The watcher then sends a one-cycle abort to the engine. The abort names which command bits to clear and whether the transmit buffer must be marked empty. The watcher also holds a release request on both lines until a STOP is seen, and sets a sticky bus-collision flag. The STOP that ends a lost transfer raises the event flag.

A buffer write made while an operation is in progress is reported on a separate write-collision flag. That flag never touches the interrupt-raising flags.

Top module: `i2c_arb_watch`

## Requirements
- R1: After reset, the START-seen and STOP-seen bits, the bus-collision, write-collision and event flags, and the line-release request are all 0, and bus_free is 1.
- R2: When SDA falls while SCL has been high in both of the two latest synchronised samples, s_seen is set and p_seen is cleared. SDA changes made while SCL is low change neither bit.
- R3: When SDA rises while SCL has been high in both of the two latest synchronised samples, p_seen is set and s_seen is cleared.
- R4: bus_free is 1 when p_seen is 1, or when s_seen and p_seen are both 0. Otherwise it is 0.
- R5: A collision occurs when some bit of phase_act is 1 and sda_intent is 1 (SDA released), but SDA is sampled 0 while SCL is high. A collision sets bcol_flag. No collision occurs when sda_intent is 0, or when phase_act is all zero.
- R6: A collision gives a one-cycle abort_pulse. abort_cmd carries the in-progress condition bits of phase_act (bit0 start, bit1 repeated start, bit2 stop, bit3 acknowledge). abort_txbuf is 1 when phase_act bit4 (byte transmit) was set.
- R7: line_release goes to 1 on a collision and stays 1 until a STOP is detected on the bus.
- R8: A STOP detected while line_release is 1 sets evt_flag. evt_flag stays set until evt_clr. In the same cycle, setting wins over clearing.
- R9: bcol_flag stays set until bcol_clr is asserted. A collision in the same cycle as bcol_clr leaves the flag set.
- R10: start_grant equals start_req only while bus_free is 1 and bcol_flag is 0. Otherwise it is 0.
- R11: buf_wr while any phase_act bit is 1 sets wcol_flag and changes neither bcol_flag nor evt_flag. buf_wr with phase_act all zero has no effect. wcol_clr clears wcol_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sda_intent | input | 1 | Level the engine means to put on SDA (1 = released) |
| phase_act | input | 5 | Engine activity: bit0 start, bit1 repeated start, bit2 stop, bit3 acknowledge, bit4 byte transmit |
| buf_wr | input | 1 | Software write to the transmit buffer |
| start_req | input | 1 | Engine request to begin a START |
| bcol_clr | input | 1 | Software clear of the bus-collision flag |
| wcol_clr | input | 1 | Software clear of the write-collision flag |
| evt_clr | input | 1 | Software clear of the event flag |
| s_seen | output | 1 | START seen most recently |
| p_seen | output | 1 | STOP seen most recently |
| bus_free | output | 1 | Bus considered free |
| start_grant | output | 1 | START request accepted |
| line_release | output | 1 | Engine must release SCL and SDA |
| abort_pulse | output | 1 | One-cycle abort of the current operation |
| abort_cmd | output | 4 | Command bits to clear, valid with abort_pulse |
| abort_txbuf | output | 1 | Clear buffer-full, valid with abort_pulse |
| bcol_flag | output | 1 | Sticky bus-collision flag (raises interrupt) |
| wcol_flag | output | 1 | Sticky write-collision flag (no interrupt) |
| evt_flag | output | 1 | Event flag, set by the STOP that follows a lost transfer |

## Verification
Two pairs of actions can fall in the same cycle. A collision can be detected while software is clearing the bus-collision flag. The STOP after a lost transfer can be detected while software is clearing the event flag. The bench holds both clear inputs high across a whole acknowledge-phase collision and the STOP that follows. A bench-side recorder watches for the flags ever reaching 1. Both flags must have been seen set, and both must read 0 once the clears have taken effect. A start-phase collision is also provoked, in which the START detection and the collision happen in one cycle. That case checks that the START-seen bit and the abort both appear.

// File: rtl/i2c_arb_watch.sv
module i2c_arb_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       sda_intent,
  input  logic [4:0] phase_act,
  input  logic       buf_wr,
  input  logic       start_req,
  input  logic       bcol_clr,
  input  logic       wcol_clr,
  input  logic       evt_clr,
  output logic       s_seen,
  output logic       p_seen,
  output logic       bus_free,
  output logic       start_grant,
  output logic       line_release,
  output logic       abort_pulse,
  output logic [3:0] abort_cmd,
  output logic       abort_txbuf,
  output logic       bcol_flag,
  output logic       wcol_flag,
  output logic       evt_flag
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam int NPH  = 5;
  localparam int TXB  = NPH - 1;

  logic [SYNC_STAGES-1:0] scl_q, sda_q, int_q;
  logic [NPH-1:0]         ph_q [SYNC_STAGES];
  logic                   scl_p, sda_p;
  logic                   lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      int_q <= '0;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
      for (int i = 0; i < SYNC_STAGES; i++) ph_q[i] <= '0;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_in};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_in};
      int_q <= {int_q[SYNC_STAGES-2:0], sda_intent};
      scl_p <= scl_q[LAST];
      sda_p <= sda_q[LAST];
      ph_q[0] <= phase_act;
      for (int i = 1; i < SYNC_STAGES; i++) ph_q[i] <= ph_q[i-1];
    end
  end

  logic           scl_s, sda_s, int_d, scl_hi;
  logic [NPH-1:0] ph_d;
  logic           start_det, stop_det, collide;

  assign scl_s     = scl_q[LAST];
  assign sda_s     = sda_q[LAST];
  assign int_d     = int_q[LAST];
  assign ph_d      = ph_q[LAST];
  assign scl_hi    = scl_s & scl_p;
  assign start_det = scl_hi & sda_p & ~sda_s;
  assign stop_det  = scl_hi & ~sda_p & sda_s;
  assign collide   = scl_hi & (|ph_d) & int_d & ~sda_s & ~lost;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_seen      <= 1'b0;
      p_seen      <= 1'b0;
      lost        <= 1'b0;
      bcol_flag   <= 1'b0;
      wcol_flag   <= 1'b0;
      evt_flag    <= 1'b0;
      abort_pulse <= 1'b0;
      abort_cmd   <= '0;
      abort_txbuf <= 1'b0;
    end else begin
      if (start_det) begin
        s_seen <= 1'b1;
        p_seen <= 1'b0;
      end else if (stop_det) begin
        s_seen <= 1'b0;
        p_seen <= 1'b1;
      end

      if (collide)       lost <= 1'b1;
      else if (stop_det) lost <= 1'b0;

      if (collide)       bcol_flag <= 1'b1;
      else if (bcol_clr) bcol_flag <= 1'b0;

      if (stop_det && lost) evt_flag <= 1'b1;
      else if (evt_clr)     evt_flag <= 1'b0;

      if (buf_wr && (|phase_act)) wcol_flag <= 1'b1;
      else if (wcol_clr)          wcol_flag <= 1'b0;

      abort_pulse <= collide;
      abort_cmd   <= collide ? ph_d[3:0] : '0;
      abort_txbuf <= collide & ph_d[TXB];
    end
  end

  assign line_release = lost;
  assign bus_free     = p_seen | ~(s_seen | p_seen);
  assign start_grant  = start_req & bus_free & ~bcol_flag;

  p_start_sets_s_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (s_seen && !p_seen));

  p_stop_sets_p_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (p_seen && !s_seen));

  p_busy_not_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_seen && !p_seen) |-> !bus_free);

  p_collide_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> (bcol_flag && line_release && abort_pulse));

  p_abort_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  p_abort_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> line_release);

  p_evt_after_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(line_release));

  p_bcol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bcol_flag && !bcol_clr) |=> bcol_flag);

  p_grant_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_grant |-> (!bcol_flag && bus_free));

  p_wcol_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && (phase_act == '0) && !wcol_flag) |=> !wcol_flag);

endmodule

// File: tb/test_i2c_arb_watch.sv
`timescale 1ns/1ps
module test_i2c_arb_watch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, sda_intent = 1'b0;
  logic [4:0] phase_act = '0;
  logic buf_wr = 1'b0, start_req = 1'b0;
  logic bcol_clr = 1'b0, wcol_clr = 1'b0, evt_clr = 1'b0;
  logic s_seen, p_seen, bus_free, start_grant, line_release, abort_pulse;
  logic [3:0] abort_cmd;
  logic abort_txbuf, bcol_flag, wcol_flag, evt_flag;

  always #2 clk = ~clk;

  i2c_arb_watch i_i2c_arb_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_intent(sda_intent), .phase_act(phase_act), .buf_wr(buf_wr),
    .start_req(start_req), .bcol_clr(bcol_clr), .wcol_clr(wcol_clr),
    .evt_clr(evt_clr), .s_seen(s_seen), .p_seen(p_seen), .bus_free(bus_free),
    .start_grant(start_grant), .line_release(line_release),
    .abort_pulse(abort_pulse), .abort_cmd(abort_cmd), .abort_txbuf(abort_txbuf),
    .bcol_flag(bcol_flag), .wcol_flag(wcol_flag), .evt_flag(evt_flag));

  logic       cap_clear = 1'b0;
  logic [3:0] cap_cmd;
  logic       cap_bf, cap_bcol, cap_evt;
  always @(posedge clk) begin
    if (cap_clear) begin
      cap_cmd <= '0; cap_bf <= 1'b0; cap_bcol <= 1'b0; cap_evt <= 1'b0;
    end else begin
      if (abort_pulse) begin
        cap_cmd <= cap_cmd | abort_cmd;
        cap_bf  <= cap_bf | abort_txbuf;
      end
      if (bcol_flag) cap_bcol <= 1'b1;
      if (evt_flag)  cap_evt  <= 1'b1;
    end
  end

  // obs bits: 0 s,1 p,2 free,3 bcol,4 wcol,5 evt,6 release,7 grant,8-11 cmd,12 txbuf,13 bcol seen,14 evt seen
  logic [15:0] obs;
  assign obs = {1'b0, cap_evt, cap_bcol, cap_bf, cap_cmd, start_grant, line_release,
                evt_flag, wcol_flag, bcol_flag, bus_free, p_seen, s_seen};

  string       tq[$];
  logic [15:0] mq[$], eq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_obs(input string tag, input logic [15:0] mask, input logic [15:0] exp);
    tq.push_back(tag); mq.push_back(mask); eq.push_back(exp);
  endtask

  task automatic clear_caps();
    cap_clear = 1'b1; step(1); cap_clear = 1'b0;
  endtask

  always @(negedge clk) begin
    while (tq.size() > 0) begin
      string t; logic [15:0] m, e;
      t = tq.pop_front(); m = mq.pop_front(); e = eq.pop_front();
      checks++;
      if ((obs & m) !== (e & m)) begin
        fails++;
        $display("FAIL %s: actual %h expected %h (mask %h)", t, obs & m, e & m, m);
      end
    end
  end

  localparam logic [15:0] M_S = 16'h0001, M_P = 16'h0002, M_F = 16'h0004,
    M_BC = 16'h0008, M_WC = 16'h0010, M_EV = 16'h0020, M_RL = 16'h0040,
    M_GR = 16'h0080, M_CMD = 16'h0F00, M_BF = 16'h1000, M_SB = 16'h2000, M_SE = 16'h4000;

  initial begin
    step(3);
    rst_n = 1'b1;
    clear_caps();
    step(1);
    expect_obs("R1 reset state", M_S|M_P|M_F|M_BC|M_WC|M_EV|M_RL, M_F);

    sda_in = 1'b0; step(6);
    expect_obs("R2 start sets S", M_S|M_P, M_S);
    expect_obs("R4 busy after start", M_F, 16'h0);
    scl_in = 1'b0; step(4); sda_in = 1'b1; step(4); sda_in = 1'b0; step(6);
    expect_obs("R2 SDA moves with SCL low", M_S|M_P, M_S);
    scl_in = 1'b1; step(6); sda_in = 1'b1; step(6);
    expect_obs("R3 stop sets P", M_S|M_P, M_P);
    expect_obs("R4 free after stop", M_F, M_F);

    start_req = 1'b1; step(1);
    expect_obs("R10 grant when free", M_GR, M_GR);

    sda_in = 1'b0; step(6); scl_in = 1'b0; step(6);
    phase_act = 5'b10000; sda_intent = 1'b0; step(6);
    scl_in = 1'b1; step(6);
    expect_obs("R5 no collision when driving low", M_BC|M_RL, 16'h0);
    scl_in = 1'b0; step(6);
    phase_act = 5'b00000; sda_intent = 1'b1; step(6);
    scl_in = 1'b1; step(6);
    expect_obs("R5 no collision when idle phase", M_BC|M_RL, 16'h0);
    scl_in = 1'b0; step(6);

    phase_act = 5'b10000; buf_wr = 1'b1; step(1); buf_wr = 1'b0; step(3);
    expect_obs("R11 write during transmit", M_WC|M_BC|M_EV, M_WC);
    wcol_clr = 1'b1; step(1); wcol_clr = 1'b0; step(2);
    expect_obs("R11 wcol cleared", M_WC, 16'h0);
    phase_act = 5'b00000; buf_wr = 1'b1; step(1); buf_wr = 1'b0; step(3);
    expect_obs("R11 write while idle ignored", M_WC, 16'h0);

    clear_caps();
    phase_act = 5'b10000; sda_intent = 1'b1; step(6);
    scl_in = 1'b1; step(6);
    expect_obs("R5 data collision", M_BC|M_RL, M_BC|M_RL);
    expect_obs("R6 transmit abort", M_CMD|M_BF, M_BF);
    expect_obs("R10 grant refused after collision", M_GR, 16'h0);
    phase_act = 5'b00000; sda_intent = 1'b0;
    scl_in = 1'b0; step(6); scl_in = 1'b1; step(6);
    expect_obs("R7 release held until stop", M_RL, M_RL);
    sda_in = 1'b1; step(6);
    expect_obs("R8 stop after loss sets event", M_RL|M_EV|M_P, M_EV|M_P);
    expect_obs("R9 bcol sticky through stop", M_BC, M_BC);
    evt_clr = 1'b1; step(1); evt_clr = 1'b0; step(2);
    expect_obs("R8 event cleared", M_EV, 16'h0);
    bcol_clr = 1'b1; step(1); bcol_clr = 1'b0; step(2);
    expect_obs("R9 bcol cleared", M_BC, 16'h0);
    expect_obs("R10 grant back", M_GR, M_GR);

    clear_caps();
    phase_act = 5'b00001; sda_intent = 1'b1; step(2);
    sda_in = 1'b0; step(6);
    expect_obs("R6 start-phase abort with start seen", M_S|M_BC|M_CMD|M_BF, M_S|M_BC|16'h0100);
    phase_act = 5'b00000; sda_intent = 1'b0;
    sda_in = 1'b1; step(6);
    bcol_clr = 1'b1; evt_clr = 1'b1; step(3);

    clear_caps();
    phase_act = 5'b01000; sda_intent = 1'b1;
    scl_in = 1'b0; step(6); sda_in = 1'b0; step(6); scl_in = 1'b1; step(6);
    expect_obs("R9 collision wins over clear", M_SB|M_CMD, M_SB|16'h0800);
    phase_act = 5'b00000; sda_intent = 1'b0;
    sda_in = 1'b1; step(6);
    expect_obs("R8 event set wins over clear", M_SE|M_RL, M_SE);
    expect_obs("R9 flags cleared after clears held", M_BC|M_EV, 16'h0);
    bcol_clr = 1'b0; evt_clr = 1'b0; start_req = 1'b0;
    step(3);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule